// File: doc/BRIEF.md
# Endian-Selectable Byte Memory

This block is a synchronous data memory in which every address holds one byte. It has a single request port that accepts loads and stores one, two or four bytes wide. A store writes its value into consecutive byte addresses starting at the request address. A load gathers the same span of bytes and returns them zero-extended on a 32-bit bus.

A mode input sets how a multi-byte value is split across those addresses. In big-endian mode the most significant byte goes to the lowest address. In little-endian mode the least significant byte goes there. The mode is sampled on every request. A store in one mode followed by a narrower load, or a load in the other mode, therefore shows the byte order that was actually written.

Requests that are not aligned to their own width, or that carry the unused size code, are rejected. They raise an error pulse and leave the storage untouched.

Top module: `endian_byte_mem`

## Requirements
- R1: Each byte address holds exactly one byte, and an accepted 4-byte store fills the four consecutive addresses from its base address upward.
- R2: With `big_endian`=1, a store puts the most significant byte of the value at the lowest address and the least significant byte at the highest. For example, 0xA1B2C3D4 stored at 0x20 leaves A1, B2, C3, D4 at 0x20..0x23.
- R3: With `big_endian`=0, a store puts the least significant byte at the lowest address. The same example leaves D4, C3, B2, A1 at 0x20..0x23.
- R4: A 4-byte load issued in the same mode as the 4-byte store that wrote the location returns the stored value.
- R5: A narrower load returns a subset of the bytes written by a wider store, ordered by the load's own mode. After the example store, a 2-byte load at base+2 gives 0xC3D4 in big-endian mode and 0xA1B2 in little-endian mode. A 1-byte load at base+1 gives 0xB2 in big-endian mode and 0xC3 in little-endian mode.
- R6: `req_size` uses 2'b00 for 1 byte, 2'b01 for 2 bytes and 2'b10 for 4 bytes. The code 2'b11 is illegal: it raises `access_err` and neither writes memory nor produces load data.
- R7: A 2-byte access at an odd address, or a 4-byte access at an address that is not a multiple of 4, raises `access_err` one cycle later. It modifies no byte and does not assert `rd_valid`.
- R8: A store takes effect at the rising clock edge that accepts it. Load data appears on `rd_data` with `rd_valid` high for exactly the one cycle after the request. Loads narrower than 4 bytes are zero-extended.
- R9: Changing `big_endian` affects only requests issued after the change and never reorders bytes that are already stored.
- R10: After a synchronous reset (`rst_n` low at a clock edge), `rd_valid`, `access_err` and `rd_data` are all zero.
- R11: A 1-byte or 2-byte store changes only the addresses it covers, and neighbouring bytes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the lowest byte accessed |
| req_size | input | 2 | Access width code (00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, 11 = illegal) |
| big_endian | input | 1 | Byte order for this request (1 = big-endian, 0 = little-endian) |
| wr_data | input | 32 | Store value, right-aligned for narrow stores |
| rd_data | output | 32 | Registered, zero-extended load result |
| rd_valid | output | 1 | `rd_data` holds a new load result this cycle |
| access_err | output | 1 | The previous cycle's request was misaligned or had an illegal size |

## Verification
Wrong state inside this block, such as a lane enable on the wrong bank or a byte placed in the mirrored lane, does not show up when it happens. It shows up only on a later load that covers the damaged byte. The error appears one cycle after that load is issued, as a wrong byte in a specific lane of `rd_data`.

For that reason each store is read back at every width and in both modes. The reads also include addresses next to the ones written, so a stray write lane is caught on the first load that touches it. A wrongly decoded request shows up sooner: `access_err` or `rd_valid` is wrong in the very next cycle.

// File: rtl/endmem_pkg.sv
// Package: shared constants and the access-width code for the endian memory.
// Assumes a 32-bit data bus built from four 8-bit lanes.
package endmem_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 4;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;
endpackage

// File: rtl/endmem_access_dec.sv
// Module: decodes the size code and the low address bits of a request.
// It produces the byte count, the per-bank enables and a fault flag.
// Assumes the banks are interleaved by the low address bits.
module endmem_access_dec
    import endmem_pkg::*;
(
    input  logic [1:0]       size_code,
    input  logic [1:0]       offs,
    output logic             fault,
    output logic [2:0]       nbytes,
    output logic [LANES-1:0] lane_en
);
    // Width decode and alignment test.
    always_comb begin
        fault  = 1'b0;
        nbytes = 3'd1;
        case (acc_size_e'(size_code))
            SZ_BYTE: nbytes = 3'd1;
            SZ_HALF: begin nbytes = 3'd2; fault = offs[0]; end
            SZ_WORD: begin nbytes = 3'd4; fault = |offs; end
            default: begin nbytes = 3'd0; fault = 1'b1; end
        endcase
    end

    // A bank is enabled when its distance from the base falls inside the access.
    always_comb begin
        for (int b = 0; b < LANES; b++) begin
            lane_en[b] = !fault && (b >= int'(offs)) && (b - int'(offs) < int'(nbytes));
        end
    end

    // A legal access enables exactly as many banks as it has bytes (R6, R7).
    always_comb begin
        if (!fault) assert_lane_count_R6: assert ($countones(lane_en) == int'(nbytes));
        else        assert_fault_no_lane_R7: assert (lane_en == '0);
    end
endmodule

// File: rtl/endmem_lane_map.sv
// Module: both byte-order networks.
// Store side: spreads a right-aligned value onto the bank lanes.
// Load side: collects bank bytes back into a right-aligned value.
// Assumes the access is legal: offs + nbytes never exceeds LANES.
module endmem_lane_map
    import endmem_pkg::*;
(
    input  logic [1:0]        offs,
    input  logic [2:0]        nbytes,
    input  logic              big,
    input  logic [DATA_W-1:0] st_value,
    output logic [DATA_W-1:0] st_lanes,
    input  logic [DATA_W-1:0] ld_lanes,
    output logic [DATA_W-1:0] ld_value
);
    // Store path: bank b receives access byte k = b - offs, taken from the
    // value end that the mode selects.
    always_comb begin
        st_lanes = '0;
        for (int b = 0; b < LANES; b++) begin
            int k;
            int v;
            k = b - int'(offs);
            v = 0;
            if (k >= 0 && k < int'(nbytes)) begin
                v = big ? (int'(nbytes) - 1 - k) : k;
            end
            st_lanes[b*LANE_W +: LANE_W] = st_value[v*LANE_W +: LANE_W];
        end
    end

    // Load path: access byte k comes from bank offs + k and is placed in the
    // value byte the mode selects; bytes beyond the width stay zero.
    always_comb begin
        ld_value = '0;
        for (int k = 0; k < LANES; k++) begin
            int b;
            int v;
            b = int'(offs) + k;
            v = big ? (int'(nbytes) - 1 - k) : k;
            if (k < int'(nbytes) && b < LANES && v >= 0) begin
                ld_value[v*LANE_W +: LANE_W] = ld_lanes[b*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/endmem_bank.sv
// Module: one byte-wide storage bank with a synchronous write and an
// asynchronous read. Contents are not reset.
module endmem_bank #(
    parameter int ROW_W  = 6,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] rbyte
);
    localparam int ROWS = 1 << ROW_W;

    logic [BYTE_W-1:0] mem [ROWS];

    // Write the addressed row on the clock edge.
    always_ff @(posedge clk) begin
        if (we) mem[row] <= wbyte;
    end

    // Read the addressed row combinationally.
    assign rbyte = mem[row];
endmodule

// File: rtl/endian_byte_mem.sv
// Module: byte-addressed memory with 1/2/4-byte loads and stores and a
// per-request byte order. Storage is split into interleaved banks selected by
// the low address bits. Load results and the error pulse are registered.
// Assumes one request per cycle at most; rd_data holds between loads.
module endian_byte_mem
    import endmem_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              big_endian,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              access_err
);
    localparam int OFF_W = $clog2(LANES);
    localparam int ROW_W = ADDR_W - OFF_W;

    logic [OFF_W-1:0]  offs;
    logic [ROW_W-1:0]  row;
    logic              fault;
    logic [2:0]        nbytes;
    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] st_lanes;
    logic [DATA_W-1:0] ld_lanes;
    logic [DATA_W-1:0] ld_value;

    assign offs = req_addr[OFF_W-1:0];
    assign row  = req_addr[ADDR_W-1:OFF_W];

    endmem_access_dec u_dec (
        .size_code (req_size),
        .offs      (offs),
        .fault     (fault),
        .nbytes    (nbytes),
        .lane_en   (lane_en)
    );

    endmem_lane_map u_map (
        .offs     (offs),
        .nbytes   (nbytes),
        .big      (big_endian),
        .st_value (wr_data),
        .st_lanes (st_lanes),
        .ld_lanes (ld_lanes),
        .ld_value (ld_value)
    );

    // One bank per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_bank
        endmem_bank #(.ROW_W(ROW_W), .BYTE_W(LANE_W)) u_bank (
            .clk   (clk),
            .we    (req_valid && req_write && lane_en[g]),
            .row   (row),
            .wbyte (st_lanes[g*LANE_W +: LANE_W]),
            .rbyte (ld_lanes[g*LANE_W +: LANE_W])
        );
    end

    // Output registers: load result, its valid strobe and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data    <= '0;
            rd_valid   <= 1'b0;
            access_err <= 1'b0;
        end else begin
            rd_valid   <= req_valid && !req_write && !fault;
            access_err <= req_valid && fault;
            if (req_valid && !req_write && !fault) rd_data <= ld_value;
        end
    end

    // A result strobe and an error pulse never coincide (R7).
    assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && access_err));

    // The illegal size code always produces an error pulse (R6).
    assert_bad_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b11) |=> access_err);

    // A result strobe follows only a load request (R8).
    assert_valid_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    // A 1-byte load result is zero above its low byte (R8).
    assert_zext_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_size) == 2'b00) |-> rd_data[31:8] == '0);

    // A 2-byte load result is zero above its low half (R8).
    assert_zext_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_size) == 2'b01) |-> rd_data[31:16] == '0);

    // Without a new load, rd_data holds its value.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));
endmodule

// File: tb/endian_byte_mem_test.sv
// Bench: directed scenarios for endian_byte_mem, each task checks itself.
module endian_byte_mem_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic [7:0]  req_addr;
    logic [1:0]  req_size;
    logic        big_endian;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        access_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    endian_byte_mem #(.ADDR_W(8)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .big_endian (big_endian),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .access_err (access_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one request at a falling edge; it is taken at the next rising
    // edge, and outputs are sampled at the falling edge after that.
    task automatic issue(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                         input bit be, input logic [31:0] d);
        req_valid  = 1'b1;
        req_write  = wr;
        req_addr   = a;
        req_size   = sz;
        big_endian = be;
        wr_data    = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic load_chk(input string tag, input logic [7:0] a, input logic [1:0] sz,
                            input bit be, input logic [31:0] exp);
        issue(1'b0, a, sz, be, 32'h0);
        check({tag, " valid"}, {31'b0, rd_valid}, 32'd1);
        check({tag, " data"}, rd_data, exp);
    endtask

    task automatic t_reset;
        check("R10 rd_valid", {31'b0, rd_valid}, 32'd0);
        check("R10 access_err", {31'b0, access_err}, 32'd0);
        check("R10 rd_data", rd_data, 32'd0);
    endtask

    task automatic t_big_endian;
        issue(1'b1, 8'h20, 2'b10, 1'b1, 32'hA1B2C3D4);
        load_chk("R2 R1 byte 0x20", 8'h20, 2'b00, 1'b1, 32'hA1);
        load_chk("R2 R1 byte 0x21", 8'h21, 2'b00, 1'b1, 32'hB2);
        load_chk("R2 R1 byte 0x22", 8'h22, 2'b00, 1'b1, 32'hC3);
        load_chk("R2 R1 byte 0x23", 8'h23, 2'b00, 1'b1, 32'hD4);
        load_chk("R4 word be", 8'h20, 2'b10, 1'b1, 32'hA1B2C3D4);
        load_chk("R5 half be 0x22", 8'h22, 2'b01, 1'b1, 32'h0000C3D4);
        load_chk("R5 half be 0x20", 8'h20, 2'b01, 1'b1, 32'h0000A1B2);
    endtask

    task automatic t_little_endian;
        issue(1'b1, 8'h40, 2'b10, 1'b0, 32'hA1B2C3D4);
        load_chk("R3 byte 0x40", 8'h40, 2'b00, 1'b0, 32'hD4);
        load_chk("R3 byte 0x41", 8'h41, 2'b00, 1'b0, 32'hC3);
        load_chk("R3 byte 0x42", 8'h42, 2'b00, 1'b0, 32'hB2);
        load_chk("R3 byte 0x43", 8'h43, 2'b00, 1'b0, 32'hA1);
        load_chk("R4 word le", 8'h40, 2'b10, 1'b0, 32'hA1B2C3D4);
        load_chk("R5 half le 0x42", 8'h42, 2'b01, 1'b0, 32'h0000A1B2);
        load_chk("R5 byte le 0x41", 8'h41, 2'b00, 1'b0, 32'h000000C3);
    endtask

    task automatic t_mode_switch;
        load_chk("R9 byte after switch", 8'h20, 2'b00, 1'b0, 32'hA1);
        load_chk("R9 word other mode", 8'h20, 2'b10, 1'b0, 32'hD4C3B2A1);
        load_chk("R9 half other mode", 8'h22, 2'b01, 1'b0, 32'h0000D4C3);
        load_chk("R9 word back", 8'h20, 2'b10, 1'b1, 32'hA1B2C3D4);
    endtask

    task automatic t_narrow_store;
        issue(1'b1, 8'h21, 2'b00, 1'b1, 32'hFFFFFF55);
        load_chk("R11 byte store", 8'h20, 2'b10, 1'b1, 32'hA155C3D4);
        issue(1'b1, 8'h22, 2'b01, 1'b0, 32'h00001234);
        load_chk("R11 half store le", 8'h20, 2'b10, 1'b1, 32'hA1553412);
        issue(1'b1, 8'h20, 2'b01, 1'b1, 32'h00009876);
        load_chk("R11 half store be", 8'h20, 2'b10, 1'b1, 32'h98763412);
        load_chk("R11 neighbour 0x24", 8'h24, 2'b10, 1'b1, 32'h0BADF00D);
    endtask

    task automatic t_faults;
        issue(1'b1, 8'h60, 2'b10, 1'b1, 32'h01234567);
        check("R7 good store no err", {31'b0, access_err}, 32'd0);
        issue(1'b1, 8'h60, 2'b11, 1'b1, 32'hFFFFFFFF);
        check("R6 illegal size err", {31'b0, access_err}, 32'd1);
        issue(1'b0, 8'h60, 2'b11, 1'b1, 32'h0);
        check("R6 illegal load err", {31'b0, access_err}, 32'd1);
        check("R6 illegal load no valid", {31'b0, rd_valid}, 32'd0);
        issue(1'b1, 8'h61, 2'b01, 1'b1, 32'hFFFFFFFF);
        check("R7 odd half err", {31'b0, access_err}, 32'd1);
        issue(1'b1, 8'h62, 2'b10, 1'b0, 32'hFFFFFFFF);
        check("R7 word misalign err", {31'b0, access_err}, 32'd1);
        issue(1'b0, 8'h63, 2'b01, 1'b1, 32'h0);
        check("R7 misaligned load err", {31'b0, access_err}, 32'd1);
        check("R7 misaligned load no valid", {31'b0, rd_valid}, 32'd0);
        load_chk("R7 R6 memory unchanged", 8'h60, 2'b10, 1'b1, 32'h01234567);
        check("R7 err cleared", {31'b0, access_err}, 32'd0);
    endtask

    task automatic t_timing;
        load_chk("R8 zext byte", 8'h63, 2'b00, 1'b1, 32'h00000067);
        @(negedge clk);
        check("R8 valid one cycle", {31'b0, rd_valid}, 32'd0);
        check("R8 data held", rd_data, 32'h00000067);
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr = '0;
        req_size = '0;
        big_endian = 1'b0;
        wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        issue(1'b1, 8'h24, 2'b10, 1'b1, 32'h0BADF00D);
        t_big_endian();
        t_little_endian();
        t_mode_switch();
        t_narrow_store();
        t_faults();
        t_timing();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule